// File: doc/BRIEF.md
# Stack Pointer Delta Tracker

This unit sits on the decode side of a processor front end and watches each decoded instruction as it passes. It recognises the four implicit stack operations: push, pop, call and return. It folds each one's pointer adjustment into a running signed offset, using a small adder of its own. The back end therefore receives no separate pointer-update micro-op for these instructions. The unit flags each such instruction as having its update absorbed, and reports the pointer offset that instruction sees.

When an instruction names the stack pointer as an explicit operand, the back end needs the true architectural value. If the tracked offset is not zero at that point, the unit requests one sync micro-op that carries the offset, and it then restarts from zero. It also issues a sync when an update would carry the offset past the range it can hold. In that case the update is then applied to a fresh zero offset. A pipeline flush discards the offset.

All outputs are registered and appear one clock after the instruction is presented.

Top module: `sp_delta_tracker`

## Requirements
- R1: While reset is asserted and after it is released, out_valid, out_suppress, sync_valid, out_offset and sync_delta are all zero, and the tracked offset starts at zero.
- R2: The operation code on in_op is 0 for non-stack, 1 for push, 2 for pop, 3 for call and 4 for return. The byte size is 1 << in_size, so in_size 0/1/2/3 gives 1/2/4/8 bytes. Push and call subtract the size from the tracked offset.
- R3: Pop and return add the size to the tracked offset.
- R4: A valid stack operation with in_sp_explicit low produces, one cycle later, out_valid=1 and out_suppress=1. out_offset holds the offset after the update, as an 8-bit two's-complement value.
- R5: A valid instruction with in_sp_explicit high, arriving while the offset is nonzero, produces sync_valid=1 with sync_delta equal to the old offset. out_valid=1, out_suppress=0 and out_offset=0 appear in the same cycle, and the offset becomes zero. This holds whatever in_op is.
- R6: An explicit-pointer instruction arriving while the offset is zero produces no sync, and the offset stays zero.
- R7: If a stack update would leave the range -128..127, the unit outputs sync_valid=1 with the old offset, out_suppress=1, and an out_offset equal to the signed size alone. The offset becomes that value.
- R8: flush takes priority over in_valid. On the next cycle there is no output and no sync, and the offset is zero.
- R9: A valid non-stack, non-explicit instruction gives out_valid=1 and out_suppress=0, and out_offset equals the unchanged offset. A cycle with in_valid low gives no output and leaves the offset unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Pipeline flush, clears the offset |
| in_valid | input | 1 | Decoded instruction present |
| in_op | input | 3 | Stack operation code |
| in_size | input | 2 | Log2 of operand size in bytes |
| in_sp_explicit | input | 1 | Instruction reads or writes the stack pointer explicitly |
| out_valid | output | 1 | Result for the instruction of the previous cycle |
| out_suppress | output | 1 | Pointer-update micro-op absorbed |
| out_offset | output | 8 | Pointer offset seen by the instruction |
| sync_valid | output | 1 | Emit a sync micro-op |
| sync_delta | output | 8 | Offset carried by the sync |

## Verification
The hardest situations to reach are the two range edges, because the offset moves by at most 8 bytes per instruction. The bench walks the offset up with a run of 8-byte pops until the next one would reach +128. It then walks it down with 8-byte pushes to exactly -128, which must still be legal. A single 1-byte push then has to trigger the sync. The bench reads the hidden offset back through a plain non-stack instruction after a flush and after an idle cycle.

// File: rtl/sp_trk_pkg.sv
package sp_trk_pkg;
    typedef enum logic [2:0] {
        OP_NONE = 3'd0,
        OP_PUSH = 3'd1,
        OP_POP  = 3'd2,
        OP_CALL = 3'd3,
        OP_RET  = 3'd4
    } stk_op_e;
endpackage

// File: rtl/sp_op_decode.sv
module sp_op_decode #(
    parameter int SIZE_W = 2,
    localparam int MAG_W = 1 << SIZE_W
) (
    input  logic [2:0]        op,
    input  logic [SIZE_W-1:0] size,
    output logic              is_stack,
    output logic              is_down,
    output logic [MAG_W-1:0]  mag
);
    import sp_trk_pkg::*;

    always_comb begin
        is_stack = 1'b0;
        is_down  = 1'b0;
        case (op)
            OP_PUSH, OP_CALL: begin is_stack = 1'b1; is_down = 1'b1; end
            OP_POP,  OP_RET:  begin is_stack = 1'b1; is_down = 1'b0; end
            default:          begin is_stack = 1'b0; is_down = 1'b0; end
        endcase
        mag = MAG_W'(1) << size;
    end
endmodule

// File: rtl/sp_delta_adder.sv
module sp_delta_adder #(
    parameter int DELTA_W = 8,
    parameter int MAG_W   = 4
) (
    input  logic [DELTA_W-1:0] delta,
    input  logic [MAG_W-1:0]   mag,
    input  logic               down,
    output logic [DELTA_W-1:0] sum,
    output logic [DELTA_W-1:0] fresh,
    output logic               ovf
);
    logic [DELTA_W:0] ext, step, wide, neg_step;

    always_comb begin
        ext      = {delta[DELTA_W-1], delta};
        step     = {{(DELTA_W+1-MAG_W){1'b0}}, mag};
        neg_step = '0 - step;
        wide     = down ? (ext - step) : (ext + step);
        ovf      = wide[DELTA_W] ^ wide[DELTA_W-1];
        sum      = wide[DELTA_W-1:0];
        fresh    = down ? neg_step[DELTA_W-1:0] : step[DELTA_W-1:0];
    end
endmodule

// File: rtl/sp_delta_tracker.sv
module sp_delta_tracker #(
    parameter int DELTA_W = 8,
    parameter int SIZE_W  = 2,
    localparam int MAG_W  = 1 << SIZE_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flush,
    input  logic               in_valid,
    input  logic [2:0]         in_op,
    input  logic [SIZE_W-1:0]  in_size,
    input  logic               in_sp_explicit,
    output logic               out_valid,
    output logic               out_suppress,
    output logic [DELTA_W-1:0] out_offset,
    output logic               sync_valid,
    output logic [DELTA_W-1:0] sync_delta
);
    typedef struct packed {
        logic [DELTA_W-1:0] delta;
        logic               out_v;
        logic               out_s;
        logic [DELTA_W-1:0] out_o;
        logic               sync_v;
        logic [DELTA_W-1:0] sync_d;
    } trk_state_t;

    trk_state_t st_d, st_q;

    logic               is_stack, is_down, ovf;
    logic [MAG_W-1:0]   mag;
    logic [DELTA_W-1:0] sum, fresh;

    sp_op_decode #(.SIZE_W(SIZE_W)) i_dec (
        .op(in_op), .size(in_size),
        .is_stack(is_stack), .is_down(is_down), .mag(mag)
    );

    sp_delta_adder #(.DELTA_W(DELTA_W), .MAG_W(MAG_W)) i_add (
        .delta(st_q.delta), .mag(mag), .down(is_down),
        .sum(sum), .fresh(fresh), .ovf(ovf)
    );

    always_comb begin
        st_d        = st_q;
        st_d.out_v  = 1'b0;
        st_d.out_s  = 1'b0;
        st_d.out_o  = '0;
        st_d.sync_v = 1'b0;
        st_d.sync_d = '0;
        if (flush) begin
            st_d.delta = '0;
        end else if (in_valid) begin
            st_d.out_v = 1'b1;
            if (in_sp_explicit) begin
                if (st_q.delta != '0) begin
                    st_d.sync_v = 1'b1;
                    st_d.sync_d = st_q.delta;
                end
                st_d.delta = '0;
            end else if (is_stack) begin
                st_d.out_s = 1'b1;
                if (ovf) begin
                    st_d.sync_v = 1'b1;
                    st_d.sync_d = st_q.delta;
                    st_d.delta  = fresh;
                end else begin
                    st_d.delta = sum;
                end
                st_d.out_o = st_d.delta;
            end else begin
                st_d.out_o = st_q.delta;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid    = st_q.out_v;
    assign out_suppress = st_q.out_s;
    assign out_offset   = st_q.out_o;
    assign sync_valid   = st_q.sync_v;
    assign sync_delta   = st_q.sync_d;

    assert_flush_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (!out_valid && !sync_valid && st_q.delta == '0));

    assert_sync_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sync_valid |-> (sync_delta != '0));

    assert_supp_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_suppress |-> out_valid);

    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid && !flush) |=> $stable(st_q.delta));

    assert_explicit_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !flush && in_sp_explicit) |=> (st_q.delta == '0 && out_offset == '0));
endmodule

// File: tb/test_sp_delta_tracker.sv
`timescale 1ns/1ps
module test_sp_delta_tracker;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       flush = 1'b0;
    logic       in_valid = 1'b0;
    logic [2:0] in_op = '0;
    logic [1:0] in_size = '0;
    logic       in_sp_explicit = 1'b0;
    logic       out_valid, out_suppress, sync_valid;
    logic [7:0] out_offset, sync_delta;

    int tests = 0;
    int fails = 0;

    always #4 clk = ~clk;

    sp_delta_tracker i_sp_delta_tracker (
        .clk(clk), .rst_n(rst_n), .flush(flush), .in_valid(in_valid),
        .in_op(in_op), .in_size(in_size), .in_sp_explicit(in_sp_explicit),
        .out_valid(out_valid), .out_suppress(out_suppress), .out_offset(out_offset),
        .sync_valid(sync_valid), .sync_delta(sync_delta)
    );

    typedef struct packed {
        logic [2:0] op;
        logic [1:0] sz;
        logic       ex;
        logic       supp;
        logic [7:0] off;
        logic       sv;
        logic [7:0] sd;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t TBL [NV] = '{
        '{3'd1, 2'd2, 1'b0, 1'b1, 8'hFC, 1'b0, 8'h00}, // R2 push 4
        '{3'd3, 2'd2, 1'b0, 1'b1, 8'hF8, 1'b0, 8'h00}, // R2 call 4
        '{3'd2, 2'd3, 1'b0, 1'b1, 8'h00, 1'b0, 8'h00}, // R3 pop 8
        '{3'd1, 2'd0, 1'b0, 1'b1, 8'hFF, 1'b0, 8'h00}, // R2 push 1
        '{3'd4, 2'd1, 1'b0, 1'b1, 8'h01, 1'b0, 8'h00}, // R3 ret 2
        '{3'd0, 2'd2, 1'b0, 1'b0, 8'h01, 1'b0, 8'h00}, // R9 plain
        '{3'd0, 2'd2, 1'b1, 1'b0, 8'h00, 1'b1, 8'h01}, // R5 explicit sync
        '{3'd0, 2'd2, 1'b1, 1'b0, 8'h00, 1'b0, 8'h00}, // R6 explicit at zero
        '{3'd1, 2'd2, 1'b1, 1'b0, 8'h00, 1'b0, 8'h00}, // R6 explicit push
        '{3'd2, 2'd3, 1'b0, 1'b1, 8'h08, 1'b0, 8'h00}  // R4 pop 8
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic [2:0] op, input logic [1:0] sz,
                         input logic ex, input logic fl);
        in_valid = v; in_op = op; in_size = sz; in_sp_explicit = ex; flush = fl;
        @(negedge clk);
        in_valid = 1'b0; flush = 1'b0; in_sp_explicit = 1'b0;
    endtask

    task automatic expect_out(input string req, input logic v, input logic s,
                              input logic [7:0] o, input logic sv, input logic [7:0] sd);
        chk({req, " valid"}, {7'b0, out_valid}, {7'b0, v});
        chk({req, " suppress"}, {7'b0, out_suppress}, {7'b0, s});
        chk({req, " offset"}, out_offset, o);
        chk({req, " sync"}, {7'b0, sync_valid}, {7'b0, sv});
        chk({req, " sync_delta"}, sync_delta, sd);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        expect_out("R1 in reset", 1'b0, 1'b0, 8'h00, 1'b0, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        expect_out("R1 after reset", 1'b0, 1'b0, 8'h00, 1'b0, 8'h00);

        for (int i = 0; i < NV; i++) begin
            drive(1'b1, TBL[i].op, TBL[i].sz, TBL[i].ex, 1'b0);
            expect_out($sformatf("R4 vec%0d", i), 1'b1, TBL[i].supp, TBL[i].off,
                       TBL[i].sv, TBL[i].sd);
        end

        // offset is 8: walk up to 120 with 8-byte pops (R3)
        for (int i = 0; i < 14; i++) drive(1'b1, 3'd2, 2'd3, 1'b0, 1'b0);
        expect_out("R3 reach 120", 1'b1, 1'b1, 8'h78, 1'b0, 8'h00);
        // R7 positive overflow
        drive(1'b1, 3'd4, 2'd3, 1'b0, 1'b0);
        expect_out("R7 pos overflow", 1'b1, 1'b1, 8'h08, 1'b1, 8'h78);
        // walk from 8 down to -128 exactly (R2)
        for (int i = 0; i < 17; i++) drive(1'b1, 3'd1, 2'd3, 1'b0, 1'b0);
        expect_out("R2 reach -128", 1'b1, 1'b1, 8'h80, 1'b0, 8'h00);
        // R7 negative overflow by one byte
        drive(1'b1, 3'd3, 2'd0, 1'b0, 1'b0);
        expect_out("R7 neg overflow", 1'b1, 1'b1, 8'hFF, 1'b1, 8'h80);

        // R9 idle cycle keeps offset
        drive(1'b0, 3'd1, 2'd3, 1'b0, 1'b0);
        expect_out("R9 idle", 1'b0, 1'b0, 8'h00, 1'b0, 8'h00);
        drive(1'b1, 3'd0, 2'd0, 1'b0, 1'b0);
        expect_out("R9 readback", 1'b1, 1'b0, 8'hFF, 1'b0, 8'h00);

        // R8 flush beats a valid push
        drive(1'b1, 3'd1, 2'd2, 1'b0, 1'b1);
        expect_out("R8 flush", 1'b0, 1'b0, 8'h00, 1'b0, 8'h00);
        drive(1'b1, 3'd0, 2'd0, 1'b0, 1'b0);
        expect_out("R8 readback", 1'b1, 1'b0, 8'h00, 1'b0, 8'h00);

        // R5 explicit push while offset nonzero: sync, not suppressed
        drive(1'b1, 3'd3, 2'd2, 1'b0, 1'b0);
        expect_out("R2 call", 1'b1, 1'b1, 8'hFC, 1'b0, 8'h00);
        drive(1'b1, 3'd1, 2'd2, 1'b1, 1'b0);
        expect_out("R5 explicit push", 1'b1, 1'b0, 8'h00, 1'b1, 8'hFC);
        drive(1'b1, 3'd0, 2'd0, 1'b0, 1'b0);
        expect_out("R5 cleared", 1'b1, 1'b0, 8'h00, 1'b0, 8'h00);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule